// File: doc/BRIEF.md
# Copy-Descriptor Ring Walker

This block steps through a circular ring of memory-copy descriptors kept in system memory. Each slot holds four 32-bit words. The first word is the ownership and length word. The second carries the upper 16 address bits of the destination (bits 15:0) and of the source (bits 31:16). The third and fourth hold the lower 32 bits of the destination and of the source. The walker reads a slot through a word-wide memory port and stops at once if the slot is not owned. For an owned slot it reads the remaining three words and hands one copy command to a downstream mover. When the mover responds, the walker overwrites the slot's first word with a completion word.

Software places the ring by giving a 48-bit base address and a slot count. It chooses the next slot to visit with a load strobe and begins walking with a start pulse. The walker moves on to the following slot by itself after each clean completion, and goes back to the base after the last slot. It goes idle at the first slot it does not own, and halts after any slot whose copy reported an error. Three one-cycle events report what happened: a completion, an unowned slot and a mover error. An idle flag shows when the walker is waiting for a new start.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset `idle` is 1, `mem_req`, `mv_req` and all three events are 0, and the slot pointer is 0.
- R2: While idle, `ptr_load` sets the next slot index to `ptr_slot`, and `start` begins by reading word 0 at `ring_base + 16*slot`. While the walker is busy, both `ptr_load` and `start` are ignored.
- R3: If bit 31 of word 0 is 0, the walker pulses `inv_evt` for one cycle, returns to idle and writes nothing. The next `start` reads the same slot again.
- R4: For an owned slot the walker reads the words at +4, +8 and +12. It then raises `mv_req` with `mv_len` = word0[26:0], `mv_dst` = {word1[15:0], word2} and `mv_src` = {word1[31:16], word3}, and holds these until `mv_done`.
- R5: After `mv_done` the walker writes word 0 of the same slot with bit 31 = 0, bit 30 = 1 when there is no error, bit 29 = read error, bit 28 = write error, bit 27 = 0, and bits 26:0 = length minus bytes moved (0 if more bytes were moved than asked for).
- R6: `done_evt` pulses for one cycle after the write-back is acknowledged, only when there was no error and bit 30 of the slot's word 0 was set.
- R7: A read or write error still causes the write-back. Then `err_evt` pulses and the walker goes idle with the pointer on the following slot, and a new `start` continues from that slot.
- R8: After slot `ring_slots`-1 the walker moves to slot 0, the base address.
- R9: After a clean completion the walker reads the following slot without a new `start`, and continues until it meets an unowned slot or an error.
- R10: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`. Only write-backs use `mem_we` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | 48 | Byte address of slot 0 |
| ring_slots | input | SLOT_W | Number of slots in the ring |
| ptr_load | input | 1 | Load the next slot index (honoured only when idle) |
| ptr_slot | input | SLOT_W | Slot index to load |
| start | input | 1 | Begin walking (honoured only when idle) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 48 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data is valid in this cycle |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Copy command pending |
| mv_dst | output | 48 | Copy destination address |
| mv_src | output | 48 | Copy source address |
| mv_len | output | 27 | Bytes to copy |
| mv_done | input | 1 | Mover finished; result inputs are valid |
| mv_moved | input | 27 | Bytes actually moved |
| mv_rd_err | input | 1 | Mover read failure |
| mv_wr_err | input | 1 | Mover write failure |
| done_evt | output | 1 | Clean completion with interrupt request |
| inv_evt | output | 1 | Unowned slot met |
| err_evt | output | 1 | Copy failed, walker halted |
| idle | output | 1 | Walker waiting for start |

## Verification
The walker is tested on a four-slot ring. The sweep covers every pairing of the interrupt-request bit with each mover outcome: clean, read fail, write fail and both. It also covers partial transfers and two memory latencies, so the done, error and unowned events can be told apart by slot and by cause. Multi-slot runs show that walking continues on its own and wraps from the last slot to the base. Repeated starts on an unowned slot show that the pointer does not move. Strobes pulsed during a long copy show that `ptr_load` and `start` are ignored while busy.

// File: rtl/rw_pkg.sv
// Package: shared widths, descriptor field positions, walker states and the
// captured descriptor type used by the ring walker.
package rw_pkg;
    localparam int unsigned ADDR_W   = 48;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LEN_W    = 27;
    localparam int unsigned HI_W     = 16;
    localparam int unsigned OWN_BIT  = 31;
    localparam int unsigned IRQ_BIT  = 30;
    localparam int unsigned OK_BIT   = 30;
    localparam int unsigned RDF_BIT  = 29;
    localparam int unsigned WRF_BIT  = 28;
    localparam int unsigned SLOT_SH  = 4;   // 16 bytes per slot

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_MOVE, ST_WB
    } rw_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [LEN_W-1:0]  len;
        logic              irq;
    } rw_desc_t;
endpackage

// File: rtl/rw_slot_ptr.sv
// Slot pointer: holds the index of the next slot to visit, loads it on
// request, steps it with wrap-around, and forms the slot byte address.
// Assumes ring_slots >= 1; an index at or past the count wraps to 0.
module rw_slot_ptr #(
    parameter int unsigned SLOT_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [rw_pkg::ADDR_W-1:0] base,
    input  logic [SLOT_W-1:0]         slots,
    input  logic                      load,
    input  logic [SLOT_W-1:0]         load_idx,
    input  logic                      advance,
    output logic [SLOT_W-1:0]         idx,
    output logic [rw_pkg::ADDR_W-1:0] slot_addr
);
    import rw_pkg::*;

    logic at_last;

    // Last slot when the following index reaches the count.
    assign at_last = ({1'b0, idx} + 1'b1) >= {1'b0, slots};

    // Pointer register: load, step or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (load)
            idx <= load_idx;
        else if (advance)
            idx <= at_last ? '0 : idx + 1'b1;
    end

    // Byte address of the current slot.
    assign slot_addr = base + (ADDR_W'(idx) << SLOT_SH);

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && slots != '0 && idx == slots - 1'b1) |=> idx == '0);
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !at_last) |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/rw_desc_regs.sv
// Descriptor capture: stores the fields of the slot being processed as its
// four words arrive. Assumes one word per capture strobe, selected by sel.
module rw_desc_regs (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap,
    input  logic [1:0]                sel,
    input  logic [rw_pkg::WORD_W-1:0] rdata,
    output rw_pkg::rw_desc_t          desc
);
    import rw_pkg::*;

    // Field capture by word position inside the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc <= '0;
        end else if (cap) begin
            case (sel)
                2'd0: begin
                    desc.len <= rdata[LEN_W-1:0];
                    desc.irq <= rdata[IRQ_BIT];
                end
                2'd1: begin
                    desc.dst[ADDR_W-1 -: HI_W] <= rdata[HI_W-1:0];
                    desc.src[ADDR_W-1 -: HI_W] <= rdata[WORD_W-1 -: HI_W];
                end
                2'd2: desc.dst[WORD_W-1:0] <= rdata;
                default: desc.src[WORD_W-1:0] <= rdata;
            endcase
        end
    end
endmodule

// File: rtl/rw_wb_fmt.sv
// Completion word builder: combines the requested length, the bytes moved
// and the two error flags into the word written back over slot word 0.
// Residue saturates at zero when the mover reports more than requested.
module rw_wb_fmt (
    input  logic [rw_pkg::LEN_W-1:0]  len,
    input  logic [rw_pkg::LEN_W-1:0]  moved,
    input  logic                      rd_err,
    input  logic                      wr_err,
    output logic [rw_pkg::WORD_W-1:0] word
);
    import rw_pkg::*;

    logic [LEN_W-1:0] residue;

    // Bytes left over, never negative.
    assign residue = (moved >= len) ? '0 : len - moved;

    // Pack status bits and residue.
    always_comb begin
        word = '0;
        word[LEN_W-1:0] = residue;
        word[OK_BIT]    = !(rd_err || wr_err);
        word[RDF_BIT]   = rd_err;
        word[WRF_BIT]   = wr_err;
        word[OWN_BIT]   = 1'b0;
    end
endmodule

// File: rtl/desc_ring_walker.sv
// Ring walker top: sequences slot reads, the copy command and the
// completion write-back, and raises the three event pulses.
// Assumes memory and mover hold their responses for one cycle each and
// never acknowledge without a pending request.
module desc_ring_walker #(
    parameter int unsigned SLOT_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [rw_pkg::ADDR_W-1:0] ring_base,
    input  logic [SLOT_W-1:0]         ring_slots,
    input  logic                      ptr_load,
    input  logic [SLOT_W-1:0]         ptr_slot,
    input  logic                      start,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [rw_pkg::ADDR_W-1:0] mem_addr,
    output logic [rw_pkg::WORD_W-1:0] mem_wdata,
    input  logic                      mem_ack,
    input  logic [rw_pkg::WORD_W-1:0] mem_rdata,
    output logic                      mv_req,
    output logic [rw_pkg::ADDR_W-1:0] mv_dst,
    output logic [rw_pkg::ADDR_W-1:0] mv_src,
    output logic [rw_pkg::LEN_W-1:0]  mv_len,
    input  logic                      mv_done,
    input  logic [rw_pkg::LEN_W-1:0]  mv_moved,
    input  logic                      mv_rd_err,
    input  logic                      mv_wr_err,
    output logic                      done_evt,
    output logic                      inv_evt,
    output logic                      err_evt,
    output logic                      idle
);
    import rw_pkg::*;

    rw_state_e        state;
    rw_desc_t         desc;
    logic [SLOT_W-1:0] cur_idx;
    logic [ADDR_W-1:0] slot_addr;
    logic [1:0]       word_sel;
    logic             is_read;
    logic             cap;
    logic             adv;
    logic             load;
    logic [LEN_W-1:0] res_moved;
    logic             res_rd;
    logic             res_wr;
    logic             res_err;

    assign idle    = (state == ST_IDLE);
    assign is_read = (state == ST_RD0) || (state == ST_RD1) ||
                     (state == ST_RD2) || (state == ST_RD3);
    assign load    = idle && ptr_load;
    assign cap     = is_read && mem_ack;
    assign adv     = (state == ST_WB) && mem_ack;
    assign res_err = res_rd || res_wr;

    // Word offset inside the slot for the current access.
    always_comb begin
        case (state)
            ST_RD1:  word_sel = 2'd1;
            ST_RD2:  word_sel = 2'd2;
            ST_RD3:  word_sel = 2'd3;
            default: word_sel = 2'd0;
        endcase
    end

    rw_slot_ptr #(.SLOT_W(SLOT_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base      (ring_base),
        .slots     (ring_slots),
        .load      (load),
        .load_idx  (ptr_slot),
        .advance   (adv),
        .idx       (cur_idx),
        .slot_addr (slot_addr)
    );

    rw_desc_regs u_desc (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .sel   (word_sel),
        .rdata (mem_rdata),
        .desc  (desc)
    );

    rw_wb_fmt u_fmt (
        .len    (desc.len),
        .moved  (res_moved),
        .rd_err (res_rd),
        .wr_err (res_wr),
        .word   (mem_wdata)
    );

    // Memory and mover request outputs derived from the state.
    assign mem_req  = is_read || (state == ST_WB);
    assign mem_we   = (state == ST_WB);
    assign mem_addr = slot_addr + ADDR_W'({word_sel, 2'b00});
    assign mv_req   = (state == ST_MOVE);
    assign mv_dst   = desc.dst;
    assign mv_src   = desc.src;
    assign mv_len   = desc.len;

    // Walk sequencer with registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            done_evt  <= 1'b0;
            inv_evt   <= 1'b0;
            err_evt   <= 1'b0;
            res_moved <= '0;
            res_rd    <= 1'b0;
            res_wr    <= 1'b0;
        end else begin
            done_evt <= 1'b0;
            inv_evt  <= 1'b0;
            err_evt  <= 1'b0;
            case (state)
                ST_IDLE: if (start) state <= ST_RD0;
                ST_RD0: if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        state <= ST_RD1;
                    end else begin
                        state   <= ST_IDLE;
                        inv_evt <= 1'b1;
                    end
                end
                ST_RD1: if (mem_ack) state <= ST_RD2;
                ST_RD2: if (mem_ack) state <= ST_RD3;
                ST_RD3: if (mem_ack) state <= ST_MOVE;
                ST_MOVE: if (mv_done) begin
                    res_moved <= mv_moved;
                    res_rd    <= mv_rd_err;
                    res_wr    <= mv_wr_err;
                    state     <= ST_WB;
                end
                ST_WB: if (mem_ack) begin
                    done_evt <= !res_err && desc.irq;
                    err_evt  <= res_err;
                    state    <= res_err ? ST_IDLE : ST_RD0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mem_req && !mv_req));
    p_inv_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_evt |-> idle);
    p_mv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_done) |=> (mv_req && $stable(mv_len) &&
                                  $stable(mv_dst) && $stable(mv_src)));
    p_wb_unowned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
    p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_evt, inv_evt, err_evt}));
    p_err_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> idle);
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/sim_desc_ring_walker.sv
module sim_desc_ring_walker;
    localparam int SW = 12;
    localparam logic [47:0] BASE = 48'h0012_3456_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [47:0] ring_base = BASE;
    logic [SW-1:0] ring_slots = SW'(4);
    logic ptr_load = 1'b0;
    logic [SW-1:0] ptr_slot = '0;
    logic start = 1'b0;
    logic mem_req, mem_we, mem_ack;
    logic [47:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic mv_req, mv_done, mv_rd_err, mv_wr_err;
    logic [47:0] mv_dst, mv_src;
    logic [26:0] mv_len, mv_moved;
    logic done_evt, inv_evt, err_evt, idle;

    always #10 clk = ~clk;

    desc_ring_walker #(.SLOT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_slots(ring_slots),
        .ptr_load(ptr_load), .ptr_slot(ptr_slot), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_dst(mv_dst), .mv_src(mv_src), .mv_len(mv_len),
        .mv_done(mv_done), .mv_moved(mv_moved), .mv_rd_err(mv_rd_err),
        .mv_wr_err(mv_wr_err), .done_evt(done_evt), .inv_evt(inv_evt),
        .err_evt(err_evt), .idle(idle)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [16];
    int mem_lat = 0, mem_cnt = 0;
    int mv_lat = 1, mv_cnt = 0;
    int mv_short = 0;
    logic cfg_rd = 1'b0, cfg_wr = 1'b0;
    int c_done = 0, c_inv = 0, c_err = 0, c_cmd = 0, c_bad = 0;
    logic [47:0] last_rd0 = '0;
    logic [47:0] cap_dst [8];
    logic [47:0] cap_src [8];
    logic [26:0] cap_len [8];
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model with programmable latency.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            if (mem_cnt >= mem_lat) begin
                mem_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_addr - BASE >= 48'd64) c_bad <= c_bad + 1;
                if (mem_we) mem[4'((mem_addr - BASE) >> 2)] <= mem_wdata;
                else begin
                    mem_rdata <= mem[4'((mem_addr - BASE) >> 2)];
                    if (mem_addr[3:0] == 4'h0) last_rd0 <= mem_addr;
                end
            end else mem_cnt <= mem_cnt + 1;
        end
    end

    // Mover model: reports length minus mv_short and programmed errors.
    always @(posedge clk) begin
        mv_done <= 1'b0;
        if (rst_n && mv_req && !mv_done) begin
            if (mv_cnt >= mv_lat) begin
                mv_cnt    <= 0;
                mv_done   <= 1'b1;
                mv_moved  <= mv_len - 27'(mv_short);
                mv_rd_err <= cfg_rd;
                mv_wr_err <= cfg_wr;
                cap_dst[c_cmd % 8] <= mv_dst;
                cap_src[c_cmd % 8] <= mv_src;
                cap_len[c_cmd % 8] <= mv_len;
                c_cmd <= c_cmd + 1;
            end else mv_cnt <= mv_cnt + 1;
        end
    end

    // Event counters.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            c_done <= c_done + int'(done_evt);
            c_inv  <= c_inv + int'(inv_evt);
            c_err  <= c_err + int'(err_evt);
        end
    end

    task automatic put_desc(input int s, input bit own, input bit irq,
                            input logic [26:0] len, input logic [47:0] d,
                            input logic [47:0] sr);
        mem[s*4]   = {own, irq, 3'b000, len};
        mem[s*4+1] = {sr[47:32], d[47:32]};
        mem[s*4+2] = d[31:0];
        mem[s*4+3] = sr[31:0];
    endtask

    function automatic logic [31:0] exp_wb(input logic [26:0] len,
                                           input int shrt, input bit rd, input bit wr);
        return {1'b0, !(rd || wr), rd, wr, 1'b0, 27'(shrt)};
    endfunction

    task automatic load_ptr(input int s);
        @(negedge clk); ptr_slot = SW'(s); ptr_load = 1'b1;
        @(negedge clk); ptr_load = 1'b0;
    endtask

    task automatic go();
        int t;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        t = 0;
        while (!idle && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) chk(0, "walk timeout", 0, 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int d0, i0, e0, k0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1, "R1 idle", 64'(idle), 1);
        chk(!mem_req && !mv_req, "R1 no request", 64'({mem_req, mv_req}), 0);
        chk(!done_evt && !inv_evt && !err_evt, "R1 events",
            64'({done_evt, inv_evt, err_evt}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4/R9: slots 0 and 1 owned, slot 2 not
        put_desc(0, 1, 1, 27'd100, 48'hA1A1_0000_1000, 48'hB2B2_0000_2000);
        put_desc(1, 1, 0, 27'd200, 48'h0001_1111_1111, 48'h0002_2222_2222);
        put_desc(2, 0, 1, 27'd5, 48'h0, 48'h0);
        put_desc(3, 0, 0, 27'd5, 48'h0, 48'h0);
        start = 1'b1; ptr_load = 1'b1; ptr_slot = '0;
        @(negedge clk); start = 1'b0; ptr_load = 1'b0;
        chk(mem_req && !mem_we && mem_addr == BASE, "R2 first read address",
            64'(mem_addr), 64'(BASE));
        begin : w1
            int t = 0;
            while (!idle && t < 5000) begin @(negedge clk); t++; end
        end
        repeat (2) @(negedge clk);
        chk(c_cmd == 2, "R9 two commands without restart", 64'(c_cmd), 2);
        chk(cap_dst[0] == 48'hA1A1_0000_1000, "R4 dst slot0", 64'(cap_dst[0]), 64'hA1A1_0000_1000);
        chk(cap_src[0] == 48'hB2B2_0000_2000, "R4 src slot0", 64'(cap_src[0]), 64'hB2B2_0000_2000);
        chk(cap_len[1] == 27'd200, "R4 len slot1", 64'(cap_len[1]), 200);
        chk(cap_src[1] == 48'h0002_2222_2222, "R4 src slot1", 64'(cap_src[1]), 64'h0002_2222_2222);
        chk(mem[0] == exp_wb(27'd100, 0, 0, 0), "R5 wb slot0", 64'(mem[0]), 64'(exp_wb(27'd100, 0, 0, 0)));
        chk(mem[4] == 32'h4000_0000, "R5 wb slot1", 64'(mem[4]), 64'h4000_0000);
        chk(c_done == 1, "R6 done only with irq bit", 64'(c_done), 1);
        chk(c_inv == 1 && last_rd0 == BASE + 48'd32, "R3 stop at slot2",
            64'(last_rd0), 64'(BASE + 48'd32));
        chk(mem[8] == {1'b0, 1'b1, 3'b0, 27'd5}, "R3 unowned slot unwritten",
            64'(mem[8]), 64'({1'b0, 1'b1, 3'b0, 27'd5}));

        // R3: restart re-reads the same slot
        last_rd0 = '0;
        go();
        chk(last_rd0 == BASE + 48'd32 && c_inv == 2, "R3 re-read same slot",
            64'(last_rd0), 64'(BASE + 48'd32));

        // R2: strobes ignored while busy
        put_desc(2, 1, 0, 27'd50, 48'h10, 48'h20);
        mv_lat = 20;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        ptr_slot = '0; ptr_load = 1'b1; start = 1'b1;
        @(negedge clk); ptr_load = 1'b0; start = 1'b0;
        begin : w2
            int t = 0;
            while (!idle && t < 5000) begin @(negedge clk); t++; end
        end
        repeat (2) @(negedge clk);
        mv_lat = 1;
        chk(last_rd0 == BASE + 48'd48, "R2 busy load ignored", 64'(last_rd0), 64'(BASE + 48'd48));
        chk(c_cmd == 3, "R2 busy start ignored", 64'(c_cmd), 3);

        // R8: wrap from slot 3 to slot 0
        put_desc(3, 1, 0, 27'd64, 48'h30, 48'h40);
        put_desc(0, 1, 1, 27'd90, 48'h0007_0000_0050, 48'h60);
        put_desc(1, 0, 0, 27'd1, 48'h0, 48'h0);
        mv_short = 10;
        d0 = c_done;
        go();
        mv_short = 0;
        chk(cap_dst[4] == 48'h0007_0000_0050, "R8 wrapped to slot0", 64'(cap_dst[4]), 64'h0007_0000_0050);
        chk(mem[0] == exp_wb(27'd90, 10, 0, 0), "R5 residue after wrap",
            64'(mem[0]), 64'(exp_wb(27'd90, 10, 0, 0)));
        chk(mem[12] == exp_wb(27'd64, 10, 0, 0), "R8 slot3 written",
            64'(mem[12]), 64'(exp_wb(27'd64, 10, 0, 0)));
        chk(c_done == d0 + 1 && last_rd0 == BASE + 48'd16, "R6 R9 wrap walk",
            64'(c_done - d0), 1);

        // R5/R6/R7 sweep: outcome x irq x memory latency
        for (int kind = 0; kind < 4; kind++) begin
            for (int irq = 0; irq < 2; irq++) begin
                int s = (kind * 2 + irq) % 4;
                int ns = (s + 1) % 4;
                logic [26:0] ln = 27'(40 + kind * 8 + irq);
                put_desc(s, 1, irq[0], ln, 48'(s * 256), 48'(s * 512));
                mem[ns*4] = '0;
                cfg_rd = kind[0]; cfg_wr = kind[1];
                mv_short = kind;
                mem_lat = irq * 2;
                d0 = c_done; i0 = c_inv; e0 = c_err; k0 = c_cmd;
                load_ptr(s);
                go();
                chk(mem[s*4] == exp_wb(ln, kind, kind[0], kind[1]), "R5 sweep wb",
                    64'(mem[s*4]), 64'(exp_wb(ln, kind, kind[0], kind[1])));
                chk(c_done - d0 == int'(kind == 0 && irq == 1), "R6 sweep done",
                    64'(c_done - d0), 64'(kind == 0 && irq == 1));
                chk(c_err - e0 == int'(kind != 0), "R7 sweep error",
                    64'(c_err - e0), 64'(kind != 0));
                chk(c_inv - i0 == int'(kind == 0), "R3 sweep stop",
                    64'(c_inv - i0), 64'(kind == 0));
                if (kind != 0) begin
                    last_rd0 = '0;
                    go();
                    chk(last_rd0 == BASE + 48'(ns * 16) && c_cmd == k0 + 1,
                        "R7 resume at following slot", 64'(last_rd0),
                        64'(BASE + 48'(ns * 16)));
                end
            end
        end
        cfg_rd = 1'b0; cfg_wr = 1'b0; mv_short = 0; mem_lat = 0;
        chk(c_bad == 0, "R10 addresses inside ring", 64'(c_bad), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cyc > 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule